// File: doc/BRIEF.md
# Colour Window Interrupt with Persistence

This block watches the results of one chosen colour channel (green, red or blue) and decides when a light level has stayed outside a programmed 16-bit window long enough to be worth an alarm. Every time the chosen channel delivers a result, that result is compared against a low bound and a high bound. The block latches an interrupt flag only after a run of 1, 2, 4 or 8 consecutive out-of-window results. When the flag is latched, the block asks the open-drain interrupt pad to pull low.

The flag and the pad request stay active until the surrounding logic reports that the status register has been read out. Conversions keep arriving and being judged while the flag is held. The same pad can also report finished conversions when that option is on. When the pad is turned into a synchronisation input, the block stops driving it, but it still keeps its flag. Register storage and the serial bus sit outside this block. They hand it the thresholds, the configuration fields and a one-cycle pulse that marks a completed status read.

Top module: `rgb_window_irq`

## Requirements
- R1: Channel select code 2'b00 disables window monitoring, so no result can set the flag. Code 2'b01 monitors green (result lane 0), 2'b10 monitors red (lane 1) and 2'b11 monitors blue (lane 2). Strobes on lanes that are not selected are ignored.
- R2: A selected result counts as out of window when it is less than or equal to `thr_lo`, or strictly greater than `thr_hi`. A result equal to `thr_hi`, or lying between the bounds, is in window.
- R3: Persistence code 0, 1, 2 or 3 requires 1, 2, 4 or 8 consecutive out-of-window results. `thr_flag` rises at the clock edge that samples the last result of the run. A shorter run leaves the flag low.
- R4: Any in-window result of the selected channel resets the consecutive count to zero.
- R5: A change of `chan_sel` or `persist_code` resets the consecutive count to zero. A result sampled in the same cycle as the change is discarded.
- R6: Once set, `thr_flag` stays high until `status_read_done` pulses. Further results, whether in or out of window, do not clear it.
- R7: When `status_read_done` coincides with a completing run, the clear wins: the flag stays low and counting restarts from zero.
- R8: With `done_irq_en` high, a `conv_done` pulse latches a request that drives `irq_drive_low` until the next `status_read_done`. With `done_irq_en` low, `conv_done` has no effect on the pad. `thr_flag` is never affected by `conv_done`.
- R9: While `sync_mode` is high, `irq_drive_low` is 0. `thr_flag` still sets and holds normally, and the pad is requested again once `sync_mode` returns low.
- R10: After reset, `thr_flag` and `irq_drive_low` are 0 and the consecutive count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | NUM_CH (3) | Per-lane result strobes: lane 0 green, 1 red, 2 blue |
| res_data | input | NUM_CH*DATA_W (48) | Packed results; lane k occupies bits [k*16 +: 16] |
| thr_lo | input | DATA_W (16) | Low window bound (inclusive out-of-window) |
| thr_hi | input | DATA_W (16) | High window bound |
| chan_sel | input | 2 | Monitored channel: 00 none, 01 green, 10 red, 11 blue |
| persist_code | input | 2 | Run length code: 1, 2, 4 or 8 results |
| conv_done | input | 1 | One-cycle pulse when a conversion completes |
| done_irq_en | input | 1 | Lets conversion completion request the pad |
| sync_mode | input | 1 | Pad used as sync input; block never drives it |
| status_read_done | input | 1 | One-cycle pulse at the end of a status register read |
| thr_flag | output | 1 | Latched window interrupt status |
| irq_drive_low | output | 1 | Enable for the open-drain pull-down of the interrupt pad |

## Verification
The sharp case is a status read landing in the same cycle as the result that completes a persistence run. The clear and the trigger then both aim at the flag register on one edge. The bench provokes this by strobing the final out-of-window result while `status_read_done` is high. It then checks that the flag stays low. It also checks that two further out-of-window results are needed (with a run length of 2) before the flag sets again, which proves that the count restarted. A second same-cycle collision, a configuration change arriving together with a result, is also provoked. The result must be discarded.

// File: rtl/rgb_irq_pkg.sv
package rgb_irq_pkg;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'b00,
        SEL_GREEN = 2'b01,
        SEL_RED   = 2'b10,
        SEL_BLUE  = 2'b11
    } chan_sel_e;

    typedef struct packed {
        logic flag;
        logic done_pend;
    } hold_state_t;

endpackage

// File: rtl/rgb_irq_window.sv
module rgb_irq_window #(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 3,
    localparam int SEL_W = $clog2(NUM_CH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        res_valid,
    input  logic [NUM_CH*DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0]        thr_lo,
    input  logic [DATA_W-1:0]        thr_hi,
    input  logic [SEL_W-1:0]         sel_i,
    output logic                     ev_o,
    output logic                     out_o
);

    logic [NUM_CH-1:0] lane_out;
    logic [NUM_CH-1:0] lane_hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        logic [DATA_W-1:0] lane_val;
        assign lane_val    = res_data[g*DATA_W +: DATA_W];
        assign lane_out[g] = (lane_val <= thr_lo) || (lane_val > thr_hi);
        assign lane_hit[g] = res_valid[g] && (sel_i == SEL_W'(g + 1));
    end

    always_comb begin
        ev_o  = 1'b0;
        out_o = 1'b0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (lane_hit[k]) begin
                ev_o  = 1'b1;
                out_o = lane_out[k];
            end
        end
    end

    // R1: with monitoring disabled no result event may leave this stage
    p_no_event_when_off_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == '0) |-> !ev_o);

    // R1: a selected-lane event only exists when some lane strobed
    p_event_needs_strobe_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        ev_o |-> (res_valid != '0));

endmodule

// File: rtl/rgb_irq_persist.sv
module rgb_irq_persist #(
    parameter int SEL_W      = 2,
    parameter int PERS_CODES = 4,
    localparam int CODE_W    = $clog2(PERS_CODES),
    localparam int PERS_MAX  = 1 << (PERS_CODES - 1),
    localparam int CNT_W     = $clog2(PERS_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ev_i,
    input  logic              out_i,
    output logic              trig_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [SEL_W-1:0]  sel;
        logic [CODE_W-1:0] code;
    } pers_state_t;

    pers_state_t st_d, st_q;
    logic        cfg_chg;
    logic [CNT_W:0] need;
    logic [CNT_W:0] run;

    always_comb begin
        st_d    = st_q;
        st_d.sel  = sel_i;
        st_d.code = code_i;
        cfg_chg = (sel_i != st_q.sel) || (code_i != st_q.code);
        need    = (CNT_W + 1)'(1) << code_i;
        run     = {1'b0, st_q.cnt} + (CNT_W + 1)'(1);
        trig_o  = 1'b0;
        if (cfg_chg) begin
            st_d.cnt = '0;
        end else if (ev_i) begin
            if (out_i) begin
                if (run >= need) begin
                    trig_o   = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = run[CNT_W-1:0];
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: with stable configuration the run count stays below the required length
    p_cnt_below_need_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |-> ({1'b0, st_q.cnt} < need));

    // R4: an in-window result empties the run
    p_in_window_clears_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && !out_i) |=> (st_q.cnt == '0));

    // R5: a configuration change empties the run
    p_cfg_change_clears_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (st_q.cnt == '0));

endmodule

// File: rtl/rgb_irq_hold.sv
module rgb_irq_hold
    import rgb_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic conv_done_i,
    input  logic done_en_i,
    input  logic clear_i,
    input  logic sync_i,
    output logic flag_o,
    output logic drive_low_o
);

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.flag      = 1'b0;
            st_d.done_pend = 1'b0;
        end else begin
            st_d.flag      = st_q.flag || trig_i;
            st_d.done_pend = st_q.done_pend || (conv_done_i && done_en_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o      = st_q.flag;
    assign drive_low_o = !sync_i && (st_q.flag || st_q.done_pend);

    // R6: the flag holds until a status read
    p_flag_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clear_i) |=> st_q.flag);

    // R7: a status read always leaves the flag low, even against a trigger
    p_clear_wins_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !st_q.flag);

    // R3: the flag only rises after a completed run
    p_flag_needs_trig_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(trig_i));

endmodule

// File: rtl/rgb_window_irq.sv
module rgb_window_irq
    import rgb_irq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_CH     = 3,
    parameter int PERS_CODES = 4,
    localparam int SEL_W     = $clog2(NUM_CH + 1),
    localparam int CODE_W    = $clog2(PERS_CODES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        res_valid,
    input  logic [NUM_CH*DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0]        thr_lo,
    input  logic [DATA_W-1:0]        thr_hi,
    input  logic [SEL_W-1:0]         chan_sel,
    input  logic [CODE_W-1:0]        persist_code,
    input  logic                     conv_done,
    input  logic                     done_irq_en,
    input  logic                     sync_mode,
    input  logic                     status_read_done,
    output logic                     thr_flag,
    output logic                     irq_drive_low
);

    logic sel_ev;
    logic sel_out;
    logic run_done;

    rgb_irq_window #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .sel_i     (chan_sel),
        .ev_o      (sel_ev),
        .out_o     (sel_out)
    );

    rgb_irq_persist #(
        .SEL_W      (SEL_W),
        .PERS_CODES (PERS_CODES)
    ) u_persist (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (chan_sel),
        .code_i (persist_code),
        .ev_i   (sel_ev),
        .out_i  (sel_out),
        .trig_o (run_done)
    );

    rgb_irq_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (run_done),
        .conv_done_i (conv_done),
        .done_en_i   (done_irq_en),
        .clear_i     (status_read_done),
        .sync_i      (sync_mode),
        .flag_o      (thr_flag),
        .drive_low_o (irq_drive_low)
    );

    // R9: the pad is never pulled while it serves as a sync input
    p_sync_releases_pad_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |-> !irq_drive_low);

    // R8: without the completion option the pad follows the window flag only
    p_done_gated_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (!done_irq_en && !sync_mode && !thr_flag && !$past(done_irq_en)
         && !$past(irq_drive_low)) |-> !irq_drive_low);

endmodule

// File: tb/rgb_window_irq_tb_top.sv
module rgb_window_irq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  res_valid = '0;
    logic [47:0] res_data = '0;
    logic [15:0] thr_lo = 16'd100;
    logic [15:0] thr_hi = 16'd200;
    logic [1:0]  chan_sel = 2'b00;
    logic [1:0]  persist_code = 2'b00;
    logic        conv_done = 1'b0;
    logic        done_irq_en = 1'b0;
    logic        sync_mode = 1'b0;
    logic        status_read_done = 1'b0;
    logic        thr_flag;
    logic        irq_drive_low;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rgb_window_irq dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .res_valid        (res_valid),
        .res_data         (res_data),
        .thr_lo           (thr_lo),
        .thr_hi           (thr_hi),
        .chan_sel         (chan_sel),
        .persist_code     (persist_code),
        .conv_done        (conv_done),
        .done_irq_en      (done_irq_en),
        .sync_mode        (sync_mode),
        .status_read_done (status_read_done),
        .thr_flag         (thr_flag),
        .irq_drive_low    (irq_drive_low)
    );

    // {clear_first, sel, code, lane, value, expected flag}
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 2'd1, 2'd0, 2'd0, 16'd150, 1'b0},  // R2 inside
        {1'b0, 2'd1, 2'd0, 2'd0, 16'd100, 1'b1},  // R2 equal low
        {1'b1, 2'd1, 2'd0, 2'd0, 16'd201, 1'b1},  // R2 above high
        {1'b1, 2'd1, 2'd0, 2'd0, 16'd200, 1'b0},  // R2 equal high
        {1'b1, 2'd1, 2'd0, 2'd1, 16'd5,   1'b0},  // R1 other lane
        {1'b0, 2'd2, 2'd0, 2'd1, 16'd5,   1'b1},  // R1 red
        {1'b1, 2'd3, 2'd1, 2'd2, 16'd300, 1'b0},  // R3 1 of 2
        {1'b0, 2'd3, 2'd1, 2'd2, 16'd300, 1'b1},  // R3 2 of 2
        {1'b1, 2'd3, 2'd2, 2'd2, 16'd0,   1'b0},  // R3 1 of 4
        {1'b0, 2'd3, 2'd2, 2'd2, 16'd0,   1'b0},
        {1'b0, 2'd3, 2'd2, 2'd2, 16'd0,   1'b0},
        {1'b0, 2'd3, 2'd2, 2'd2, 16'd0,   1'b1},  // R3 4 of 4
        {1'b1, 2'd3, 2'd2, 2'd2, 16'd0,   1'b0},
        {1'b0, 2'd3, 2'd2, 2'd2, 16'd150, 1'b0},  // R4 reset run
        {1'b0, 2'd3, 2'd2, 2'd2, 16'd0,   1'b0},
        {1'b0, 2'd3, 2'd2, 2'd2, 16'd0,   1'b0},
        {1'b0, 2'd3, 2'd2, 2'd2, 16'd0,   1'b0},
        {1'b0, 2'd3, 2'd2, 2'd2, 16'd0,   1'b1},  // R4 full run after reset
        {1'b1, 2'd0, 2'd0, 2'd0, 16'd0,   1'b0}   // R1 none selected
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] s, input logic [1:0] c);
        chan_sel = s;
        persist_code = c;
        tick();
    endtask

    task automatic strobe(input int lane, input logic [15:0] v, input logic clr);
        res_valid = '0;
        res_valid[lane] = 1'b1;
        res_data[lane*16 +: 16] = v;
        status_read_done = clr;
        tick();
        res_valid = '0;
        status_read_done = 1'b0;
    endtask

    task automatic clear_status();
        status_read_done = 1'b1;
        tick();
        status_read_done = 1'b0;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 flag after reset", thr_flag, 1'b0);
        check("R10 pad after reset", irq_drive_low, 1'b0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][23]) clear_status();
            set_cfg(VEC[i][22:21], VEC[i][20:19]);
            strobe(int'(VEC[i][18:17]), VEC[i][16:1], 1'b0);
            check($sformatf("R1/R2/R3/R4 vec %0d flag", i), thr_flag, VEC[i][0]);
            check($sformatf("R1/R2/R3/R4 vec %0d pad", i), irq_drive_low, VEC[i][0]);
        end

        // R3: run of 8 needs all eight results
        clear_status();
        set_cfg(2'd1, 2'd3);
        for (int k = 0; k < 7; k++) strobe(0, 16'd5, 1'b0);
        check("R3 seven of eight", thr_flag, 1'b0);
        strobe(0, 16'd5, 1'b0);
        check("R3 eight of eight", thr_flag, 1'b1);

        // R6: results keep arriving, flag holds
        strobe(0, 16'd150, 1'b0);
        strobe(0, 16'd7, 1'b0);
        check("R6 flag holds across results", thr_flag, 1'b1);
        clear_status();
        check("R6 flag cleared by status read", thr_flag, 1'b0);

        // R5: configuration change discards a partial run
        set_cfg(2'd1, 2'd1);
        strobe(0, 16'd5, 1'b0);
        set_cfg(2'd2, 2'd1);
        set_cfg(2'd1, 2'd1);
        strobe(0, 16'd5, 1'b0);
        check("R5 run reset by select change", thr_flag, 1'b0);
        strobe(0, 16'd5, 1'b0);
        check("R5 fresh run completes", thr_flag, 1'b1);
        clear_status();

        // R5: result in the change cycle is discarded
        persist_code = 2'd0;
        strobe(0, 16'd5, 1'b0);
        check("R5 result with code change discarded", thr_flag, 1'b0);

        // R7: clear coinciding with trigger
        strobe(0, 16'd5, 1'b1);
        check("R7 clear beats run length 1", thr_flag, 1'b0);
        set_cfg(2'd1, 2'd1);
        strobe(0, 16'd5, 1'b0);
        strobe(0, 16'd5, 1'b1);
        check("R7 clear beats run length 2", thr_flag, 1'b0);
        strobe(0, 16'd5, 1'b0);
        check("R7 count restarted", thr_flag, 1'b0);
        strobe(0, 16'd5, 1'b0);
        check("R7 new run completes", thr_flag, 1'b1);
        clear_status();

        // R8: conversion-done option
        conv_done = 1'b1;
        tick();
        conv_done = 1'b0;
        check("R8 done ignored when disabled", irq_drive_low, 1'b0);
        done_irq_en = 1'b1;
        conv_done = 1'b1;
        tick();
        conv_done = 1'b0;
        check("R8 done drives pad", irq_drive_low, 1'b1);
        check("R8 done leaves flag", thr_flag, 1'b0);
        tick();
        check("R8 done request held", irq_drive_low, 1'b1);
        clear_status();
        check("R8 done request cleared", irq_drive_low, 1'b0);
        done_irq_en = 1'b0;

        // R9: sync mode releases the pad
        sync_mode = 1'b1;
        set_cfg(2'd1, 2'd0);
        strobe(0, 16'd5, 1'b0);
        check("R9 flag sets in sync mode", thr_flag, 1'b1);
        check("R9 pad released in sync mode", irq_drive_low, 1'b0);
        sync_mode = 1'b0;
        #1;
        check("R9 pad returns after sync", irq_drive_low, 1'b1);
        clear_status();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule